// File: doc/BRIEF.md
# Read Transfer Active Tracker

This block keeps the "read transfer in progress" status flag of an SD-style host controller and raises a transfer-complete interrupt whenever that flag falls. A read is marked as running once the end bit of its read command has been seen, or when software resumes a read that an earlier block-gap stop had paused. The flag drops for one of three reasons. The block counter can report that the final block has reached system memory. In scatter-gather DMA mode, the descriptor table can mark the end of the read. A stop-at-gap request can also clear it, once the buffer has drained and no card-side block is still moving.

The tracker is a three-state machine: `ST_IDLE` (no read), `ST_ACTIVE` (read running, flag high) and `ST_GAP_HOLD` (read paused at a block gap, flag low, resumable). The named transitions are `T_START` (command end bit, from idle or hold to active), `T_RESUME` (continue request, from hold to active), `T_DONE_COUNT` (last counted block delivered, active to idle), `T_DONE_DESC` (descriptor end in scatter-gather mode, active to idle), `T_GAP_STOP` (drained gap stop, active to hold) and `T_SWRST` (software reset, any state to idle). Every departure from `ST_ACTIVE` other than `T_SWRST` produces one interrupt pulse, registered one clock after the flag falls.

Top module: `rd_xfer_tracker`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), `rd_active` and `xfer_done_irq` are both 0.
- R2: A one-cycle `cmd_end_pulse` sampled in idle or in the gap-hold state makes `rd_active` 1 in the following cycle.
- R3: `cont_req_wr` makes `rd_active` 1 in the following cycle only when the tracker is paused at a block gap. In idle it has no effect, and `rd_active` stays 0.
- R4: With `sg_mode` = 0, `rd_active` clears in the cycle after a `blk_done` whose `blk_remain` is 1 or 0. A `blk_done` with `blk_remain` of 2 or more leaves it set, and `desc_end` has no effect.
- R5: With `sg_mode` = 1, `rd_active` clears in the cycle after `desc_end`. A `blk_done` with `blk_remain` = 1 leaves it set.
- R6: While `gap_stop_req` is 1, `rd_active` clears only in a cycle where `buf_empty` = 1 and `blk_inflight` = 0. If either condition is missing, it stays set.
- R7: Each fall of `rd_active` that is not caused by `sw_rst` produces exactly one `xfer_done_irq` pulse, one cycle wide. The pulse is high in the second cycle after the clock edge at which the clear cause was sampled, which is the cycle after `rd_active` goes low.
- R8: If a set cause (`cmd_end_pulse`) and a clear cause are sampled together while active, `rd_active` stays 1 and no interrupt is raised.
- R9: `sw_rst` drives `rd_active` to 0 in the next cycle and overrides any set cause. It raises no interrupt, and it also cancels an interrupt that is pending from a fall in the previous cycle.
- R10: A software reset discards a gap pause, so a later `cont_req_wr` is ignored. A later `cmd_end_pulse` still starts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst | input | 1 | Synchronous software reset of the tracker |
| cmd_end_pulse | input | 1 | End bit of a read command received |
| cont_req_wr | input | 1 | Software wrote 1 to the continue request |
| gap_stop_req | input | 1 | Stop-at-block-gap request level |
| blk_done | input | 1 | One block delivered to system memory |
| blk_remain | input | CNT_W | Blocks still due, counting the one flagged by `blk_done` |
| sg_mode | input | 1 | Scatter-gather DMA mode selected |
| desc_end | input | 1 | Descriptor table marks the end of the read |
| buf_empty | input | 1 | No buffered block waits for system delivery |
| blk_inflight | input | 1 | A block is being received from the card |
| rd_active | output | 1 | Read transfer active flag |
| xfer_done_irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
The bench targets the points where causes meet or nearly meet. A non-final block count must not end the read. Descriptor end and block count must each be honoured only in their own mode. A gap stop must wait for both a drained buffer and an idle card link, so a design that checked only one of the two would drop the flag early. It also covers a set and a clear in the same cycle, where a clear-priority design would drop the flag and fire a spurious interrupt. A software reset must swallow an interrupt already pending, and must make the tracker forget a pause, so that a later continue request cannot restart the read. The bench also checks the interrupt's exact cycle and width, which catches designs that fire on the edge itself or hold the pulse for two cycles.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACTIVE   = 2'd1,
        ST_GAP_HOLD = 2'd2
    } rxt_state_e;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_COUNT = 2'd1,
        CLR_DESC  = 2'd2,
        CLR_GAP   = 2'd3
    } rxt_clr_e;

endpackage

// File: rtl/rxt_set_detect.sv
module rxt_set_detect
    import rxt_pkg::*;
(
    input  rxt_state_e state,
    input  logic       cmd_end_pulse,
    input  logic       cont_req_wr,
    output logic       set_start,
    output logic       set_resume
);

    // The command end bit starts a read from idle or hold; it also
    // counts as a set cause while active (so it beats a clear).
    // Continue applies only to a paused read.
    always_comb begin
        set_start  = cmd_end_pulse;
        set_resume = 1'b0;
        unique case (state)
            ST_IDLE:     set_resume = 1'b0;
            ST_ACTIVE:   set_resume = 1'b0;
            ST_GAP_HOLD: set_resume = cont_req_wr;
            default:     set_resume = 1'b0;
        endcase
    end

endmodule

// File: rtl/rxt_clear_detect.sv
module rxt_clear_detect
    import rxt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             sg_mode,
    input  logic             blk_done,
    input  logic [CNT_W-1:0] blk_remain,
    input  logic             desc_end,
    input  logic             gap_stop_req,
    input  logic             buf_empty,
    input  logic             blk_inflight,
    output rxt_clr_e         clr_cause
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(1);

    logic last_block;
    logic gap_drained;

    assign last_block  = blk_done && (blk_remain <= LAST_CNT);
    assign gap_drained = gap_stop_req && buf_empty && !blk_inflight;

    // A true end of transfer outranks a pause at the gap.
    always_comb begin
        clr_cause = CLR_NONE;
        if (sg_mode && desc_end) begin
            clr_cause = CLR_DESC;
        end else if (!sg_mode && last_block) begin
            clr_cause = CLR_COUNT;
        end else if (gap_drained) begin
            clr_cause = CLR_GAP;
        end
    end

endmodule

// File: rtl/rxt_fsm.sv
module rxt_fsm
    import rxt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rst,
    input  logic       set_start,
    input  logic       set_resume,
    input  rxt_clr_e   clr_cause,
    output rxt_state_e state,
    output logic       active,
    output logic       fall_evt
);

    rxt_state_e state_q;
    rxt_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (set_start) state_d = ST_ACTIVE;          // T_START
            end
            ST_ACTIVE: begin
                if (set_start) begin
                    state_d = ST_ACTIVE;                     // set wins
                end else begin
                    unique case (clr_cause)
                        CLR_COUNT: state_d = ST_IDLE;        // T_DONE_COUNT
                        CLR_DESC:  state_d = ST_IDLE;        // T_DONE_DESC
                        CLR_GAP:   state_d = ST_GAP_HOLD;    // T_GAP_STOP
                        CLR_NONE:  state_d = ST_ACTIVE;
                        default:   state_d = ST_ACTIVE;
                    endcase
                end
            end
            ST_GAP_HOLD: begin
                if (set_start || set_resume) state_d = ST_ACTIVE; // T_START / T_RESUME
            end
            default: state_d = ST_IDLE;
        endcase
        if (sw_rst) state_d = ST_IDLE;                       // T_SWRST
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        state    = state_q;
        active   = (state_q == ST_ACTIVE);
        fall_evt = (state_q == ST_ACTIVE) && (state_d != ST_ACTIVE) && !sw_rst;
    end

endmodule

// File: rtl/rxt_irq_gen.sv
module rxt_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic fall_evt,
    output logic irq
);

    logic fall_pend_q;
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_pend_q <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            fall_pend_q <= fall_evt && !sw_rst;
            irq_q       <= fall_pend_q && !sw_rst;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/rd_xfer_tracker.sv
module rd_xfer_tracker
    import rxt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             cmd_end_pulse,
    input  logic             cont_req_wr,
    input  logic             gap_stop_req,
    input  logic             blk_done,
    input  logic [CNT_W-1:0] blk_remain,
    input  logic             sg_mode,
    input  logic             desc_end,
    input  logic             buf_empty,
    input  logic             blk_inflight,
    output logic             rd_active,
    output logic             xfer_done_irq
);

    rxt_state_e state_q;
    rxt_clr_e   clr_cause;
    logic       set_start;
    logic       set_resume;
    logic       fall_evt;

    rxt_set_detect u_set (
        .state         (state_q),
        .cmd_end_pulse (cmd_end_pulse),
        .cont_req_wr   (cont_req_wr),
        .set_start     (set_start),
        .set_resume    (set_resume)
    );

    rxt_clear_detect #(.CNT_W(CNT_W)) u_clr (
        .sg_mode      (sg_mode),
        .blk_done     (blk_done),
        .blk_remain   (blk_remain),
        .desc_end     (desc_end),
        .gap_stop_req (gap_stop_req),
        .buf_empty    (buf_empty),
        .blk_inflight (blk_inflight),
        .clr_cause    (clr_cause)
    );

    rxt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .set_start  (set_start),
        .set_resume (set_resume),
        .clr_cause  (clr_cause),
        .state      (state_q),
        .active     (rd_active),
        .fall_evt   (fall_evt)
    );

    rxt_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .fall_evt (fall_evt),
        .irq      (xfer_done_irq)
    );

endmodule

// File: rtl/rxt_checker.sv
module rxt_checker
    import rxt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst,
    input logic             cmd_end_pulse,
    input logic             cont_req_wr,
    input logic             blk_done,
    input logic [CNT_W-1:0] blk_remain,
    input logic             sg_mode,
    input logic             rd_active,
    input logic             xfer_done_irq,
    input rxt_state_e       state_q
);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end_pulse && !sw_rst) |=> rd_active);

    assert_idle_cont_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cont_req_wr && !cmd_end_pulse) |=> !rd_active);

    assert_count_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && !sg_mode && blk_done && blk_remain == CNT_W'(1)
         && !cmd_end_pulse && !sw_rst) |=> !rd_active);

    assert_irq_follows_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_irq |-> ($past(rd_active, 2) && !$past(rd_active)));

    assert_irq_one_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_irq |=> !xfer_done_irq);

    assert_swrst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!rd_active && !xfer_done_irq));

    assert_swrst_no_late_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> ##1 !xfer_done_irq);

endmodule

bind rd_xfer_tracker rxt_checker #(.CNT_W(CNT_W)) u_rxt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_rst        (sw_rst),
    .cmd_end_pulse (cmd_end_pulse),
    .cont_req_wr   (cont_req_wr),
    .blk_done      (blk_done),
    .blk_remain    (blk_remain),
    .sg_mode       (sg_mode),
    .rd_active     (rd_active),
    .xfer_done_irq (xfer_done_irq),
    .state_q       (state_q)
);

// File: tb/rd_xfer_tracker_test.sv
`timescale 1ns/1ps
module rd_xfer_tracker_test;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw_rst = 1'b0;
    logic             cmd_end_pulse = 1'b0;
    logic             cont_req_wr = 1'b0;
    logic             gap_stop_req = 1'b0;
    logic             blk_done = 1'b0;
    logic [CNT_W-1:0] blk_remain = '0;
    logic             sg_mode = 1'b0;
    logic             desc_end = 1'b0;
    logic             buf_empty = 1'b0;
    logic             blk_inflight = 1'b0;
    logic             rd_active;
    logic             xfer_done_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rd_xfer_tracker #(.CNT_W(CNT_W)) uut (
        .clk (clk), .rst_n (rst_n), .sw_rst (sw_rst),
        .cmd_end_pulse (cmd_end_pulse), .cont_req_wr (cont_req_wr),
        .gap_stop_req (gap_stop_req), .blk_done (blk_done),
        .blk_remain (blk_remain), .sg_mode (sg_mode), .desc_end (desc_end),
        .buf_empty (buf_empty), .blk_inflight (blk_inflight),
        .rd_active (rd_active), .xfer_done_irq (xfer_done_irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic hard_reset();
        rst_n = 1'b0; sw_rst = 0; cmd_end_pulse = 0; cont_req_wr = 0;
        gap_stop_req = 0; blk_done = 0; blk_remain = '0; sg_mode = 0;
        desc_end = 0; buf_empty = 0; blk_inflight = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic start_read();
        cmd_end_pulse = 1; tick(); cmd_end_pulse = 0;
    endtask

    // interrupt must be low now, high one cycle later, then low again
    task automatic expect_irq(string tag);
        chk({tag, " irq not yet"}, xfer_done_irq, 1'b0);
        tick(); chk({tag, " irq pulse"}, xfer_done_irq, 1'b1);
        tick(); chk({tag, " irq width"}, xfer_done_irq, 1'b0);
    endtask

    task automatic expect_no_irq(string tag);
        chk({tag, " no irq a"}, xfer_done_irq, 1'b0);
        tick(); chk({tag, " no irq b"}, xfer_done_irq, 1'b0);
        tick(); chk({tag, " no irq c"}, xfer_done_irq, 1'b0);
    endtask

    task automatic t_reset_R1();
        hard_reset();
        chk("R1 active", rd_active, 1'b0);
        chk("R1 irq", xfer_done_irq, 1'b0);
    endtask

    task automatic t_count_R4();
        hard_reset();
        start_read();
        chk("R2 start", rd_active, 1'b1);
        blk_done = 1; blk_remain = 16'd3; tick(); blk_done = 0;
        chk("R4 non-final block", rd_active, 1'b1);
        desc_end = 1; tick(); desc_end = 0;
        chk("R4 desc_end ignored", rd_active, 1'b1);
        blk_done = 1; blk_remain = 16'd1; tick(); blk_done = 0;
        chk("R4 last block clears", rd_active, 1'b0);
        expect_irq("R7 count");
        start_read();
        blk_done = 1; blk_remain = 16'd0; tick(); blk_done = 0;
        chk("R4 remain 0 clears", rd_active, 1'b0);
        expect_irq("R7 count0");
    endtask

    task automatic t_sg_R5();
        hard_reset();
        sg_mode = 1;
        start_read();
        blk_done = 1; blk_remain = 16'd1; tick(); blk_done = 0;
        chk("R5 count ignored", rd_active, 1'b1);
        desc_end = 1; tick(); desc_end = 0;
        chk("R5 desc end clears", rd_active, 1'b0);
        expect_irq("R7 desc");
        sg_mode = 0;
    endtask

    task automatic t_gap_R6();
        hard_reset();
        start_read();
        gap_stop_req = 1; buf_empty = 0; blk_inflight = 0; tick();
        chk("R6 buffer not empty", rd_active, 1'b1);
        buf_empty = 1; blk_inflight = 1; tick();
        chk("R6 block in flight", rd_active, 1'b1);
        blk_inflight = 0; tick();
        chk("R6 drained clears", rd_active, 1'b0);
        gap_stop_req = 0;
        expect_irq("R7 gap");
        cont_req_wr = 1; tick(); cont_req_wr = 0;
        chk("R3 resume from gap", rd_active, 1'b1);
        blk_done = 1; blk_remain = 16'd1; tick(); blk_done = 0;
        chk("R4 end after resume", rd_active, 1'b0);
        expect_irq("R7 resumed end");
        gap_stop_req = 1; buf_empty = 1;
        start_read();
        chk("R2 start stays despite held gap req", rd_active, 1'b1);
        tick();
        chk("R6 pause again", rd_active, 1'b0);
        gap_stop_req = 0;
        tick(); tick();
        start_read();
        chk("R2 start from gap hold", rd_active, 1'b1);
    endtask

    task automatic t_idle_cont_R3();
        hard_reset();
        cont_req_wr = 1; tick(); cont_req_wr = 0;
        chk("R3 continue in idle", rd_active, 1'b0);
        expect_no_irq("R3 idle");
    endtask

    task automatic t_set_wins_R8();
        hard_reset();
        start_read();
        cmd_end_pulse = 1; blk_done = 1; blk_remain = 16'd1; tick();
        cmd_end_pulse = 0; blk_done = 0;
        chk("R8 set beats clear", rd_active, 1'b1);
        expect_no_irq("R8");
    endtask

    task automatic t_swrst_R9();
        hard_reset();
        start_read();
        sw_rst = 1; tick(); sw_rst = 0;
        chk("R9 sw reset clears", rd_active, 1'b0);
        expect_no_irq("R9 direct");
        start_read();
        blk_done = 1; blk_remain = 16'd1; tick(); blk_done = 0;
        chk("R9 fall before reset", rd_active, 1'b0);
        sw_rst = 1; tick(); sw_rst = 0;
        chk("R9 pending irq cancelled", xfer_done_irq, 1'b0);
        tick();
        chk("R9 no late irq", xfer_done_irq, 1'b0);
        sw_rst = 1; cmd_end_pulse = 1; tick(); sw_rst = 0; cmd_end_pulse = 0;
        chk("R9 reset beats set", rd_active, 1'b0);
    endtask

    task automatic t_swrst_gap_R10();
        hard_reset();
        start_read();
        gap_stop_req = 1; buf_empty = 1; tick(); gap_stop_req = 0;
        chk("R10 paused", rd_active, 1'b0);
        tick(); tick();
        sw_rst = 1; tick(); sw_rst = 0;
        cont_req_wr = 1; tick(); cont_req_wr = 0;
        chk("R10 continue after reset ignored", rd_active, 1'b0);
        start_read();
        chk("R10 command still starts", rd_active, 1'b1);
    endtask

    initial begin
        t_reset_R1();
        t_count_R4();
        t_sg_R5();
        t_gap_R6();
        t_idle_cont_R3();
        t_set_wins_R8();
        t_swrst_R9();
        t_swrst_gap_R10();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule